// File: doc/BRIEF.md
# Decade-Prescaled Long-Delay Timer Controller

This block is the digital core of a 555-style timer whose delay can be stretched by a power of ten. Two comparator events come in, already synchronized to `clk`. The low-trip event is `trig_evt` and the high-trip event is `thr_evt`. The block drives the timer output and a discharge enable that empties the external timing capacitor.

An internal set/clear latch follows the two events. The trigger sets the latch and the threshold clears it. When the latch is clear, discharge is enabled. With the multiplier at 1, the output is simply the latch, as in a plain 555.

With a multiplier of 10 or more, the latch keeps the capacitor oscillating. A chain of decimal digit stages counts the completed charge/discharge cycles, and the output changes only when the count reaches the multiplier. In this extended operation, a mode bit selects between two behaviours:
- Free-running: the output toggles every N cycles.
- One-shot: the output stays high for N cycles after a trigger.

The configuration byte is a plain input. It is copied into the block only while the block is idle.

Top module: `decade_delay_timer`

## Requirements
- R1: Configuration bits [2:0] pick the multiplier: 000 and 111 give 1 (counter bypassed), and code k in 001..110 gives 10^k. A code above the built stage count `NUM_DECADES` saturates at 10^NUM_DECADES.
- R2: With multiplier 1, `timer_out` equals the latch one clock after the event. A trigger sets the latch, a threshold clears it, and a threshold in the same cycle as a trigger wins. Bit 3 has no effect in this case.
- R3: With multiplier N >= 10, one charge/discharge cycle is complete when a threshold event arrives while the latch is set. Trigger and threshold events keep driving the latch, and `timer_out` does not follow the latch.
- R4: In extended free-running mode (bit 3 = 0), `timer_out` toggles on the Nth completed cycle, and counting then restarts from zero.
- R5: In extended one-shot mode (bit 3 = 1), a trigger (without a threshold) while the output is low raises `timer_out` and sets the latch. On the Nth completed cycle, `timer_out` falls and the latch clears. Trigger events while the output is high do not restart the count.
- R6: An active-low `rst_n` asynchronously clears the latch, the output and the count, giving `timer_out` = 0 and `dis_en` = 1.
- R7: `dis_en` is high exactly when the latch is clear. While a one-shot is idle, a lone threshold event changes neither output.
- R8: The configuration is copied only on a clock edge when the block is idle (latch clear, output low, count zero). A change while the block is running has no effect until it next becomes idle.
- R9: Configuration bits [7:4] have no effect on the digital behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_byte | input | 8 | Configuration: [2:0] decade code, [3] one-shot select, [7:4] analog-only |
| trig_evt | input | 1 | Low-trip comparator event, synchronized |
| thr_evt | input | 1 | High-trip comparator event, synchronized |
| timer_out | output | 1 | Timer output |
| dis_en | output | 1 | Capacitor discharge enable |

## Verification
The bench builds the block with `NUM_DECADES` = 3. With that value, the 10x and 1000x multipliers can be exercised edge to edge within the cycle budget, including the 999th/1000th-cycle boundary. Code 100 shows saturation to 1000. The full six-stage build is covered by the default elaboration and by the digit-range assertion. The directed tests also cover:
- a configuration change made while a one-shot is running;
- an asynchronous reset applied mid-count, followed by a full fresh count.

// File: rtl/ddt_pkg.sv
`timescale 1ns/1ps
package ddt_pkg;

    localparam int DIGIT_W = 4;

    typedef struct packed {
        logic       lat;   // internal set/clear latch
        logic       out;   // timer output
        logic [3:0] cfg;   // captured code and mode bit
    } ddt_state_t;

endpackage

// File: rtl/ddt_decade_counter.sv
`timescale 1ns/1ps
module ddt_decade_counter #(
    parameter int NUM_DECADES = 6,
    parameter int SEL_W       = 3
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 clr,
    input  logic                                 inc,
    input  logic [SEL_W-1:0]                     active,
    output logic                                 term,
    output logic                                 is_zero,
    output logic [ddt_pkg::DIGIT_W*NUM_DECADES-1:0] count_o
);
    localparam int DW = ddt_pkg::DIGIT_W;
    localparam int CW = DW * NUM_DECADES;

    logic [CW-1:0]          cnt_d, cnt_q;
    logic [NUM_DECADES-1:0] carry;
    logic [NUM_DECADES-1:0] nine;
    logic [NUM_DECADES-1:0] used;

    assign carry[0] = inc;

    for (genvar i = 0; i < NUM_DECADES; i++) begin : g_dig
        logic [DW-1:0] cur;
        assign cur     = cnt_q[DW*i +: DW];
        assign nine[i] = (cur == DW'(9));
        assign used[i] = (SEL_W'(i) < active);
        assign cnt_d[DW*i +: DW] = clr      ? '0 :
                                   carry[i] ? (nine[i] ? '0 : cur + DW'(1)) :
                                              cur;
        if (i < NUM_DECADES - 1) begin : g_carry
            assign carry[i+1] = carry[i] & nine[i];
        end
    end

    // terminal when every digit in use holds nine
    assign term    = &(nine | ~used);
    assign is_zero = (cnt_q == '0);
    assign count_o = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/decade_delay_timer.sv
`timescale 1ns/1ps
module decade_delay_timer #(
    parameter int NUM_DECADES = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] cfg_byte,
    input  logic       trig_evt,
    input  logic       thr_evt,
    output logic       timer_out,
    output logic       dis_en
);
    import ddt_pkg::*;

    localparam int SEL_W = $clog2(NUM_DECADES + 1);
    localparam int CW    = DIGIT_W * NUM_DECADES;

    ddt_state_t        state_d, state_q;
    logic [SEL_W-1:0]  stages;
    logic              ext_mode, mono_mode;
    logic              cnt_inc, cnt_clr, cnt_term, cnt_zero;
    logic              lat_next, cycle_done, idle;
    logic [CW-1:0]     count_v;
    logic              unused_cfg_hi;

    assign unused_cfg_hi = ^cfg_byte[7:4];

    // decode the captured code into a number of active stages
    always_comb begin
        if (state_q.cfg[2:0] == 3'd0 || state_q.cfg[2:0] == 3'd7)
            stages = '0;
        else if (int'(state_q.cfg[2:0]) > NUM_DECADES)
            stages = SEL_W'(NUM_DECADES);
        else
            stages = SEL_W'(state_q.cfg[2:0]);
    end

    assign ext_mode   = (stages != '0);
    assign mono_mode  = state_q.cfg[3];
    assign lat_next   = thr_evt ? 1'b0 : (trig_evt ? 1'b1 : state_q.lat);
    assign cycle_done = state_q.lat & thr_evt;
    assign idle       = !state_q.lat && !state_q.out && cnt_zero;

    ddt_decade_counter #(
        .NUM_DECADES(NUM_DECADES),
        .SEL_W      (SEL_W)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cnt_clr),
        .inc    (cnt_inc),
        .active (stages),
        .term   (cnt_term),
        .is_zero(cnt_zero),
        .count_o(count_v)
    );

    always_comb begin
        state_d = state_q;
        cnt_inc = 1'b0;
        cnt_clr = 1'b0;
        if (!ext_mode) begin
            state_d.lat = lat_next;
            state_d.out = lat_next;
        end else if (!mono_mode) begin
            state_d.lat = lat_next;
            if (cycle_done) begin
                if (cnt_term) begin
                    cnt_clr     = 1'b1;
                    state_d.out = !state_q.out;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
        end else if (!state_q.out) begin
            state_d.lat = 1'b0;
            if (trig_evt && !thr_evt) begin
                state_d.out = 1'b1;
                state_d.lat = 1'b1;
            end
        end else begin
            state_d.lat = lat_next;
            if (cycle_done) begin
                if (cnt_term) begin
                    cnt_clr     = 1'b1;
                    state_d.out = 1'b0;
                    state_d.lat = 1'b0;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
        end
        if (idle) state_d.cfg = cfg_byte[3:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign timer_out = state_q.out;
    assign dis_en    = !state_q.lat;
endmodule

// File: rtl/ddt_checker.sv
`timescale 1ns/1ps
module ddt_checker #(
    parameter int NUM_DECADES = 6
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        trig_evt,
    input logic                        thr_evt,
    input logic                        timer_out,
    input logic                        dis_en,
    input logic                        ext_mode,
    input logic                        mono_mode,
    input logic [4*NUM_DECADES-1:0]    count_v
);
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r6: assert (!timer_out && dis_en)
                else $error("reset did not force outputs");
        end
    end

    always @(posedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < NUM_DECADES; i++) begin
                p_digit_range_r3: assert (count_v[4*i +: 4] <= 4'd9)
                    else $error("digit out of range");
            end
        end
    end

    p_bypass_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_mode && thr_evt) |=> (!timer_out && dis_en));

    p_bypass_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_mode && trig_evt && !thr_evt) |=> (timer_out && !dis_en));

    p_astable_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_mode && !mono_mode && !thr_evt) |=> $stable(timer_out));

    p_mono_no_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_mode && mono_mode && timer_out && !thr_evt) |=> timer_out);

    p_mono_idle_discharge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_mode && mono_mode && !timer_out) |-> dis_en);
endmodule

bind decade_delay_timer ddt_checker #(.NUM_DECADES(NUM_DECADES)) u_ddt_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig_evt (trig_evt),
    .thr_evt  (thr_evt),
    .timer_out(timer_out),
    .dis_en   (dis_en),
    .ext_mode (ext_mode),
    .mono_mode(mono_mode),
    .count_v  (count_v)
);

// File: tb/decade_delay_timer_bench.sv
`timescale 1ns/1ps
module decade_delay_timer_bench;
    localparam int NDEC = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_byte = 8'h00;
    logic       trig_evt = 1'b0;
    logic       thr_evt = 1'b0;
    logic       timer_out, dis_en;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = !clk;

    decade_delay_timer #(.NUM_DECADES(NDEC)) u_decade_delay_timer (
        .clk(clk), .rst_n(rst_n), .cfg_byte(cfg_byte),
        .trig_evt(trig_evt), .thr_evt(thr_evt),
        .timer_out(timer_out), .dis_en(dis_en)
    );

    // {trig, thr, expected out, expected discharge}
    localparam logic [3:0] VEC [11] = '{
        4'b1010, 4'b0010, 4'b0101, 4'b0001, 4'b1101, 4'b1010,
        4'b1010, 4'b1101, 4'b0101, 4'b1010, 4'b0101
    };

    task automatic check(input logic got, input logic exp, input string req, input string what);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
        end
    endtask

    task automatic step(input logic t, input logic h);
        @(negedge clk);
        trig_evt = t;
        thr_evt  = h;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic [7:0] cfg);
        @(negedge clk);
        rst_n = 1'b0; cfg_byte = cfg; trig_evt = 1'b0; thr_evt = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 1'b0);
    endtask

    task automatic cycles(input int n);
        for (int k = 0; k < n; k++) begin
            step(1'b0, 1'b1);
            step(1'b1, 1'b0);
        end
    endtask

    task automatic mono_len(input logic [7:0] cfg, input int n, input string req);
        do_reset(cfg);
        step(1'b1, 1'b0);
        cycles(n - 1);
        check(timer_out, 1'b1, req, "high before last cycle");
        step(1'b0, 1'b1);
        check(timer_out, 1'b0, req, "low after last cycle");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R6 reset state
        #1;
        check(timer_out, 1'b0, "R6", "out in reset");
        check(dis_en, 1'b1, "R6", "discharge in reset");

        // R2 and R9: bypass table, with bit 3 and bits [7:4] set
        do_reset(8'hF8);
        for (int v = 0; v < 11; v++) begin
            step(VEC[v][3], VEC[v][2]);
            check(timer_out, VEC[v][1], "R2", $sformatf("vector %0d out", v));
            check(dis_en, VEC[v][0], "R7", $sformatf("vector %0d discharge", v));
        end

        // R5 and R9: one-shot x10, with a trigger while running
        do_reset(8'hB9);
        step(1'b1, 1'b0);
        check(timer_out, 1'b1, "R5", "start high");
        check(dis_en, 1'b0, "R7", "latch set at start");
        cycles(9);
        step(1'b1, 1'b0);
        check(timer_out, 1'b1, "R5", "extra trigger ignored");
        step(1'b0, 1'b1);
        check(timer_out, 1'b0, "R5", "fall at tenth cycle");
        check(dis_en, 1'b1, "R7", "discharge after end");
        step(1'b0, 1'b1);
        check(timer_out, 1'b0, "R7", "lone threshold idle out");
        check(dis_en, 1'b1, "R7", "lone threshold idle discharge");
        step(1'b1, 1'b0);
        cycles(9);
        check(timer_out, 1'b1, "R5", "retrigger fresh count");
        step(1'b0, 1'b1);
        check(timer_out, 1'b0, "R5", "retrigger falls at ten");

        // R3 and R4: free-running x10
        do_reset(8'h01);
        step(1'b1, 1'b0);
        check(timer_out, 1'b0, "R3", "out ignores latch");
        check(dis_en, 1'b0, "R3", "latch set by trigger");
        cycles(9);
        check(timer_out, 1'b0, "R4", "low after nine");
        step(1'b0, 1'b1);
        check(timer_out, 1'b1, "R4", "toggle at ten");
        step(1'b1, 1'b0);
        cycles(9);
        check(timer_out, 1'b1, "R4", "high after nineteen");
        step(1'b0, 1'b1);
        check(timer_out, 1'b0, "R4", "toggle at twenty");

        // R1: 1000x, saturated code, code 111 bypass
        mono_len(8'h0B, 1000, "R1");
        mono_len(8'h0C, 1000, "R1");
        do_reset(8'h0F);
        step(1'b1, 1'b0);
        check(timer_out, 1'b1, "R1", "code 111 bypass set");
        step(1'b0, 1'b1);
        check(timer_out, 1'b0, "R1", "code 111 bypass clear");

        // R8: configuration change while running
        do_reset(8'h09);
        step(1'b1, 1'b0);
        cfg_byte = 8'h00;
        step(1'b0, 1'b1);
        check(timer_out, 1'b1, "R8", "change ignored while running");
        step(1'b1, 1'b0);
        cycles(8);
        check(timer_out, 1'b1, "R8", "still counting ten");
        step(1'b0, 1'b1);
        check(timer_out, 1'b0, "R8", "old length kept");
        step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        check(timer_out, 1'b1, "R8", "new config set");
        step(1'b0, 1'b1);
        check(timer_out, 1'b0, "R8", "new config is bypass");

        // R6: asynchronous reset mid-count, then a fresh count
        do_reset(8'h09);
        step(1'b1, 1'b0);
        cycles(4);
        rst_n = 1'b0;
        #0.5;
        check(timer_out, 1'b0, "R6", "async reset out");
        check(dis_en, 1'b1, "R6", "async reset discharge");
        @(negedge clk);
        trig_evt = 1'b0; thr_evt = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        cycles(9);
        check(timer_out, 1'b1, "R6", "count cleared by reset");
        step(1'b0, 1'b1);
        check(timer_out, 1'b0, "R6", "full ten after reset");

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule